// File: doc/BRIEF.md
# Vector Line Refill Prefetcher

This block runs ahead of a vector memory access unit and warms the cache for it. It takes vector load commands from a command queue of its own, separate from the one that feeds the access unit. Each command carries a byte base address, a byte stride, a mode bit that selects unit-stride or strided walking, and a vector length. For each command the block works out which cache lines the load will touch and sends one refill-only request per line to the cache. The cache then holds the data by the time the access unit reaches those elements. The block moves no data.

Two throttles keep the block from harming the access unit. A miss-resource limit stops it from issuing requests while the cache's pending miss entries in use reach a configured ceiling, so some always stay free for demand misses. A lead counter tracks commands this block has taken but the access unit has not yet finished, and caps that count so prefetched lines are not evicted before they are used. A hold output asks the access unit to wait while the prefetcher is not far enough ahead and more work is queued.

Top module: `vec_refill_prefetcher`

## Requirements
- R1: `cmdReady` is high only when no command is being walked and the lead count is below `maxLead`; while a command is being walked `cmdReady` is low.
- R2: In unit-stride mode (`cmdUnit`=1, 4-byte elements) the block requests every line from `cmdBase[31:5]` up to `(cmdBase+(cmdLen-1)*4)[31:5]`, in ascending order, each exactly once.
- R3: In strided mode element i lies at `cmdBase + i*cmdStride` (modulo 2^32). The line `addr[31:5]` of the first element is always requested. Each later element is requested only when its line differs from the line of the previous request of the same command.
- R4: A command with `cmdLen`=0 is accepted and counted in the lead count but produces no request.
- R5: `reqValid` stays low while `missInUse >= missLimit`. No line is lost, and the walk resumes where it stopped.
- R6: The lead count rises by one on each accepted command and falls by one on each `accessDone` pulse. A pulse while the count is zero is ignored.
- R7: `holdAccess` is high exactly when `cmdValid` is high and the lead count is below `holdDepth`.
- R8: A request transfers on a cycle with `reqValid` and `reqReady` both high. While it waits, `reqLine` does not change.
- R9: After reset no request is pending, the lead count is zero and `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is offered by the queue |
| cmdReady | output | 1 | Command taken on this cycle if valid |
| cmdBase | input | 32 | Byte address of element 0 |
| cmdStride | input | 16 | Byte stride between elements (strided mode) |
| cmdUnit | input | 1 | 1 = unit-stride, 0 = strided |
| cmdLen | input | 8 | Number of elements |
| reqValid | output | 1 | A refill request is offered |
| reqReady | input | 1 | Cache accepts the request |
| reqLine | output | 27 | Line address (byte address bits 31:5) |
| missInUse | input | 4 | Pending miss entries currently held in the cache |
| missLimit | input | 4 | Ceiling on pending miss entries |
| accessDone | input | 1 | Access unit finished one command |
| maxLead | input | 4 | Maximum commands ahead of the access unit |
| holdDepth | input | 4 | Lead below which the access unit is held |
| holdAccess | output | 1 | Request to stall the access unit |

## Verification
A wrong line counter or stride adder shows up as a bad or missing `reqLine` value, seen on the transfer where the walk first goes wrong. A broken duplicate filter shows up as an extra or missing request in a strided walk. A drifted lead count shows up as `cmdReady` staying low too long, or `holdAccess` taking the wrong value, on the next command offer. A stall that leaks shows up as `reqValid` rising in the same cycle the miss count is at its ceiling.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef struct packed {
    logic load;
    logic advance;
    logic record;
  } dpStrobe_t;
endpackage

// File: rtl/vrp_datapath.sv
module vrp_datapath #(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int LEN_W      = 8,
  parameter int LINE_BYTES = 32,
  parameter int ELEM_BYTES = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int ELEM_SH   = $clog2(ELEM_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  vrp_pkg::dpStrobe_t    strobe,
  input  logic [ADDR_W-1:0]     cmdBase,
  input  logic [STRIDE_W-1:0]   cmdStride,
  input  logic                  cmdUnit,
  input  logic [LEN_W-1:0]      cmdLen,
  output logic [LINE_W-1:0]     candLine,
  output logic                  unitMode,
  output logic                  lastUnit,
  output logic                  lastElem,
  output logic                  dupLine
);
  logic [ADDR_W-1:0]   curAddr;
  logic [ADDR_W-1:0]   endAddr;
  logic [STRIDE_W-1:0] strideR;
  logic [LEN_W-1:0]    remain;
  logic [LINE_W-1:0]   endLine;
  logic [LINE_W-1:0]   prevLine;
  logic                hasPrev;
  logic [ADDR_W-1:0]   stepAmt;

  always_comb begin
    endAddr  = cmdBase + (ADDR_W'(cmdLen - LEN_W'(1)) << ELEM_SH);
    candLine = curAddr[ADDR_W-1:OFF_W];
    unitMode = 1'b0;
    unitMode = unitMode | unitR;
    lastUnit = (candLine == endLine);
    lastElem = (remain == LEN_W'(1));
    dupLine  = hasPrev && (candLine == prevLine);
    stepAmt  = unitR ? ADDR_W'(LINE_BYTES) : ADDR_W'(strideR);
  end

  logic unitR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      strideR  <= '0;
      remain   <= '0;
      endLine  <= '0;
      prevLine <= '0;
      hasPrev  <= 1'b0;
      unitR    <= 1'b0;
    end else if (strobe.load) begin
      curAddr  <= cmdBase;
      strideR  <= cmdStride;
      remain   <= cmdLen;
      endLine  <= endAddr[ADDR_W-1:OFF_W];
      unitR    <= cmdUnit;
      hasPrev  <= 1'b0;
    end else begin
      if (strobe.advance) begin
        curAddr <= curAddr + stepAmt;
        remain  <= remain - LEN_W'(1);
      end
      if (strobe.record) begin
        prevLine <= candLine;
        hasPrev  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vrp_control.sv
module vrp_control #(
  parameter int MISS_W = 4,
  parameter int LEAD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic               cmdLenZero,
  output logic               cmdReady,
  output logic               reqValid,
  input  logic               reqReady,
  input  logic [MISS_W-1:0]  missInUse,
  input  logic [MISS_W-1:0]  missLimit,
  input  logic               accessDone,
  input  logic [LEAD_W-1:0]  maxLead,
  input  logic [LEAD_W-1:0]  holdDepth,
  output logic               holdAccess,
  output logic [LEAD_W-1:0]  leadCount,
  output vrp_pkg::dpStrobe_t strobe,
  input  logic               unitMode,
  input  logic               lastUnit,
  input  logic               lastElem,
  input  logic               dupLine
);
  typedef enum logic {ST_IDLE, ST_WALK} walkState_t;
  walkState_t state;

  logic accept, missStall, skip, fire, finish, leadDec;

  always_comb begin
    cmdReady       = (state == ST_IDLE) && (leadCount < maxLead);
    accept         = cmdValid && cmdReady;
    missStall      = (missInUse >= missLimit);
    skip           = (state == ST_WALK) && !unitMode && dupLine;
    reqValid       = (state == ST_WALK) && !skip && !missStall;
    fire           = reqValid && reqReady;
    finish         = (fire || skip) && (unitMode ? lastUnit : lastElem);
    strobe.load    = accept && !cmdLenZero;
    strobe.advance = fire || skip;
    strobe.record  = fire;
    leadDec        = accessDone && (leadCount != '0);
    holdAccess     = cmdValid && (leadCount < holdDepth);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      leadCount <= '0;
    end else begin
      if (strobe.load)  state <= ST_WALK;
      else if (finish)  state <= ST_IDLE;
      if (accept && !leadDec)      leadCount <= leadCount + LEAD_W'(1);
      else if (!accept && leadDec) leadCount <= leadCount - LEAD_W'(1);
    end
  end
endmodule

// File: rtl/vec_refill_prefetcher.sv
module vec_refill_prefetcher #(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int LEN_W      = 8,
  parameter int LINE_BYTES = 32,
  parameter int ELEM_BYTES = 4,
  parameter int MISS_W     = 4,
  parameter int LEAD_W     = 4,
  localparam int LINE_W    = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [ADDR_W-1:0]   cmdBase,
  input  logic [STRIDE_W-1:0] cmdStride,
  input  logic                cmdUnit,
  input  logic [LEN_W-1:0]    cmdLen,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [LINE_W-1:0]   reqLine,
  input  logic [MISS_W-1:0]   missInUse,
  input  logic [MISS_W-1:0]   missLimit,
  input  logic                accessDone,
  input  logic [LEAD_W-1:0]   maxLead,
  input  logic [LEAD_W-1:0]   holdDepth,
  output logic                holdAccess
);
  vrp_pkg::dpStrobe_t strobe;
  logic unitMode, lastUnit, lastElem, dupLine;
  logic [LEAD_W-1:0] leadCount;

  vrp_control #(.MISS_W(MISS_W), .LEAD_W(LEAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdLenZero(cmdLen == '0),
    .cmdReady(cmdReady), .reqValid(reqValid), .reqReady(reqReady),
    .missInUse(missInUse), .missLimit(missLimit), .accessDone(accessDone),
    .maxLead(maxLead), .holdDepth(holdDepth), .holdAccess(holdAccess),
    .leadCount(leadCount), .strobe(strobe), .unitMode(unitMode),
    .lastUnit(lastUnit), .lastElem(lastElem), .dupLine(dupLine)
  );

  vrp_datapath #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LEN_W(LEN_W),
    .LINE_BYTES(LINE_BYTES), .ELEM_BYTES(ELEM_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdBase(cmdBase),
    .cmdStride(cmdStride), .cmdUnit(cmdUnit), .cmdLen(cmdLen),
    .candLine(reqLine), .unitMode(unitMode), .lastUnit(lastUnit),
    .lastElem(lastElem), .dupLine(dupLine)
  );
endmodule

// File: rtl/vrp_checker.sv
module vrp_checker #(
  parameter int LINE_W = 27,
  parameter int MISS_W = 4,
  parameter int LEAD_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              reqValid,
  input logic              reqReady,
  input logic [LINE_W-1:0] reqLine,
  input logic [MISS_W-1:0] missInUse,
  input logic [MISS_W-1:0] missLimit,
  input logic              accessDone,
  input logic [LEAD_W-1:0] maxLead,
  input logic [LEAD_W-1:0] leadCount,
  input logic              holdAccess
);
  assert_miss_ceiling_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (missInUse < missLimit));

  assert_lead_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |-> (leadCount < maxLead));

  assert_idle_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !reqValid);

  assert_line_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (!reqValid || $stable(reqLine)));

  assert_lead_floor_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accessDone && leadCount == '0 && !(cmdValid && cmdReady)) |=> (leadCount == '0));

  assert_hold_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdAccess |-> cmdValid);
endmodule

bind vec_refill_prefetcher vrp_checker #(
  .LINE_W(LINE_W), .MISS_W(MISS_W), .LEAD_W(LEAD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .reqValid(reqValid), .reqReady(reqReady), .reqLine(reqLine),
  .missInUse(missInUse), .missLimit(missLimit), .accessDone(accessDone),
  .maxLead(maxLead), .leadCount(leadCount), .holdAccess(holdAccess)
);

// File: tb/tb_vec_refill_prefetcher.sv
`timescale 1ns/1ps
module tb_vec_refill_prefetcher;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [31:0] cmdBase = '0;
  logic [15:0] cmdStride = '0;
  logic        cmdUnit = 1'b0;
  logic [7:0]  cmdLen = '0;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [26:0] reqLine;
  logic [3:0]  missInUse = 4'd0;
  logic [3:0]  missLimit = 4'd8;
  logic        accessDone = 1'b0;
  logic [3:0]  maxLead = 4'd4;
  logic [3:0]  holdDepth = 4'd0;
  logic        holdAccess;

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  vec_refill_prefetcher dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdBase(cmdBase), .cmdStride(cmdStride), .cmdUnit(cmdUnit), .cmdLen(cmdLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqLine(reqLine),
    .missInUse(missInUse), .missLimit(missLimit), .accessDone(accessDone),
    .maxLead(maxLead), .holdDepth(holdDepth), .holdAccess(holdAccess)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  logic [26:0] expLines[$];

  function automatic void buildExp(input logic [31:0] base, input logic [15:0] stride,
                                   input bit unit, input int len);
    logic [26:0] ln, lastLn, prev;
    logic [31:0] a;
    bit havePrev;
    expLines.delete();
    if (len == 0) return;
    if (unit) begin
      a = base + 32'(len - 1) * 32'd4;
      lastLn = a[31:5];
      ln = base[31:5];
      expLines.push_back(ln);
      while (ln != lastLn) begin
        ln = ln + 27'd1;
        expLines.push_back(ln);
      end
    end else begin
      havePrev = 1'b0;
      prev = '0;
      for (int i = 0; i < len; i++) begin
        a = base + 32'(i) * 32'(stride);
        ln = a[31:5];
        if (!havePrev || ln != prev) begin
          expLines.push_back(ln);
          prev = ln;
          havePrev = 1'b1;
        end
      end
    end
  endfunction

  task automatic offerCmd(input logic [31:0] base, input logic [15:0] stride,
                          input bit unit, input int len);
    int guard = 0;
    @(negedge clk); #1;
    while (!cmdReady && guard < 200) begin
      @(negedge clk); #1;
      guard++;
    end
    cmdBase = base; cmdStride = stride; cmdUnit = unit; cmdLen = 8'(len);
    cmdValid = 1'b1;
    @(posedge clk);
  endtask

  task automatic runCmd(input logic [31:0] base, input logic [15:0] stride,
                        input bit unit, input int len, input int stallCyc, input string req);
    int got = 0;
    int iter = 0;
    buildExp(base, stride, unit, len);
    offerCmd(base, stride, unit, len);
    while (got < expLines.size() && iter < 8 * len + 60) begin
      @(negedge clk);
      cmdValid = 1'b0;
      if (iter < stallCyc) begin
        missInUse = missLimit;
        reqReady = 1'b1;
      end else begin
        missInUse = 4'($urandom % 32'(missLimit));
        reqReady = ($urandom % 4) != 0;
      end
      #1;
      if (iter < stallCyc)
        check(!reqValid, "R5 stall", reqValid, 0);
      if (reqValid && reqReady) begin
        check(reqLine == expLines[got], req, reqLine, expLines[got]);
        got++;
      end
      iter++;
    end
    check(got == expLines.size(), {req, " count"}, got, expLines.size());
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmdValid = 1'b0;
      reqReady = 1'b1;
      missInUse = 4'd0;
      #1;
      check(!reqValid, {req, " extra"}, reqValid, 0);
    end
    accessDone = 1'b1;
    @(negedge clk);
    accessDone = 1'b0;
  endtask

  initial begin
    logic [31:0] b;
    logic [15:0] s;
    bit u;
    int l;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!reqValid, "R9 reset reqValid", reqValid, 0);
    check(cmdReady, "R9 reset cmdReady", cmdReady, 1);
    holdDepth = 4'd1; cmdValid = 1'b1; #1;
    check(holdAccess, "R9 R7 reset lead zero", holdAccess, 1);
    cmdValid = 1'b0; holdDepth = 4'd0;

    runCmd(32'h0000_0100, 16'd0, 1'b1, 8, 0, "R2 aligned one line");
    runCmd(32'h0000_011C, 16'd0, 1'b1, 2, 0, "R2 crossing pair");
    runCmd(32'h0000_0204, 16'd0, 1'b1, 64, 0, "R2 long unit");
    runCmd(32'h0000_0300, 16'd8, 1'b0, 12, 0, "R3 small stride dup");
    runCmd(32'h0000_0400, 16'd100, 1'b0, 10, 0, "R3 large stride");
    runCmd(32'h0000_0500, 16'd0, 1'b0, 9, 0, "R3 zero stride");
    runCmd(32'hFFFF_FFE0, 16'd48, 1'b0, 5, 0, "R3 wrap");
    runCmd(32'h0000_0600, 16'd4, 1'b1, 0, 0, "R4 empty command");
    runCmd(32'h0000_0700, 16'd0, 1'b1, 40, 5, "R5 resume after stall");

    for (int n = 0; n < 24; n++) begin
      u = 1'($urandom % 2);
      b = 32'($urandom % 8192);
      l = int'($urandom % 48);
      case ($urandom % 6)
        0: s = 16'd4;
        1: s = 16'd32;
        2: s = 16'd12;
        3: s = 16'd64;
        4: s = 16'd0;
        default: s = 16'($urandom % 160);
      endcase
      runCmd(b, s, u, l, 0, u ? "R2 R8 random unit" : "R3 R8 random strided");
    end

    // lead limit: two empty commands fill a lead of two
    maxLead = 4'd2;
    offerCmd(32'h0, 16'd0, 1'b1, 0);
    offerCmd(32'h0, 16'd0, 1'b1, 0);
    @(negedge clk);
    cmdValid = 1'b0; #1;
    check(!cmdReady, "R1 lead full", cmdReady, 0);
    check(!reqValid, "R4 no request", reqValid, 0);
    cmdValid = 1'b1; holdDepth = 4'd3; #1;
    check(holdAccess, "R7 hold below depth", holdAccess, 1);
    holdDepth = 4'd2; #1;
    check(!holdAccess, "R7 no hold at depth", holdAccess, 0);
    cmdValid = 1'b0; #1;
    check(!holdAccess, "R7 no hold without cmd", holdAccess, 0);
    holdDepth = 4'd0;
    accessDone = 1'b1;
    @(negedge clk); #1;
    check(cmdReady, "R6 drain reopens", cmdReady, 1);
    @(negedge clk);
    @(negedge clk);
    accessDone = 1'b0;
    #1;
    check(cmdReady, "R6 floor ready", cmdReady, 1);
    offerCmd(32'h0, 16'd0, 1'b1, 0);
    offerCmd(32'h0, 16'd0, 1'b1, 0);
    @(negedge clk);
    cmdValid = 1'b0; #1;
    check(!cmdReady, "R6 floor held at zero", cmdReady, 0);
    accessDone = 1'b1;
    @(negedge clk);
    @(negedge clk);
    accessDone = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule